// File: doc/BRIEF.md
# Chroma Key Alpha Tagger

This block sits in a video pipeline and appends an alpha plane to every pixel of a three-plane stream, one pixel per clock. Each plane is tested against its own inclusive lower and upper limit. When every plane selected by a compare mask lies inside its window, the pixel counts as a hit. A hit gets the matched alpha, and its planes selected by a replace mask are overwritten with per-plane substitute values. Any other pixel passes through untouched and carries the unmatched alpha. A build-time option turns this into a fixed-tag mode: every pixel gets a constant alpha and keeps its colour.

Software programs the keying settings through a small word-addressed register port. The writes land in a shadow copy. After a commit write, the shadow copy moves into the active copy either on the next start-of-field beat or as soon as no field is in progress. That way no field is ever keyed with a mix of old and new settings. A field-height register, which takes effect at once, tells the block how many lines form a field. The block uses it to decide when a field has ended.

Top module: `chroma_key_tagger`

## Requirements
- R1: A plane is in its window when lower <= value <= upper, with both limits inclusive. A pixel is a hit when every plane with its compare-mask bit set (bit 0 = C1 at `in_data[47:32]`, bit 1 = C2 at `[31:16]`, bit 2 = C3 at `[15:0]`) is in its window. An all-zero compare mask makes every pixel a hit.
- R2: `out_data` is `{C1, C2, C3, alpha}` with alpha in bits [15:0]. Alpha is the matched-alpha setting for a hit and the unmatched-alpha setting otherwise.
- R3: On a hit, each plane whose replace-mask bit is set (same bit order as R1) is replaced by that plane's substitute value. Every other plane, and every plane of a non-hit pixel, passes through unchanged.
- R4: With CONST_ALPHA=1, every pixel leaves with its colour unchanged and alpha equal to CONST_TAG, whatever the settings hold.
- R5: A settings write has no effect on the output until a commit write (address 0x1, any data) has been made and the transfer point of R10 has been reached.
- R6: Status bit 1 (pending, address 0x0) goes to 1 on the cycle after any write to addresses 0x2 to 0xE. It goes back to 0 when the active copy is loaded from the shadow copy.
- R7: Status bit 0 (busy) goes to 1 after an accepted start-of-field beat. It goes back to 0 after the accepted end-of-line beat that completes the number of lines held at address 0xF. A value of 0 at 0xF behaves like 1. A write to 0xF takes effect at once.
- R8: An accepted input beat appears on the output after one clock edge. While `out_valid` is high and `out_ready` is low, the output data holds steady and `in_ready` is low.
- R9: Reading address A in 0x2 to 0xE returns the shadow copy. Reading A+0x10 returns the active copy. Bits above each field's width read as zero.
- R10: A pending commit is applied on the next accepted start-of-field beat, and that beat is already keyed with the new settings. When no field is busy, the commit is applied on the clock edge after the commit write.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, the status reads 0 and every active setting reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | 48 | Pixel `{C1, C2, C3}` |
| in_sof | input | 1 | First pixel of a field |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the pixel |
| out_data | output | 64 | Pixel `{C1, C2, C3, alpha}` |
| out_sof | output | 1 | Start-of-field marker, delayed with the pixel |
| out_eol | output | 1 | End-of-line marker, delayed with the pixel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Combinational register read data |

## Verification
The bench builds two copies of the block, both with 16-bit planes and a 16-bit alpha. One uses the default keying mode. The other sets CONST_ALPHA=1 with a tag of 0x0F0F, so the fixed-tag path can be checked on the same stimulus. A short field height of two lines lets the bench commit in the middle of a field and watch the transfer wait for the field to end. A large height lets it check the transfer on a start-of-field beat that restarts a running field.

// File: rtl/ck_pkg.sv
package ck_pkg;
  localparam int NPL = 3;
  localparam logic [3:0] A_STATUS = 4'h0;
  localparam logic [3:0] A_COMMIT = 4'h1;
  localparam logic [3:0] A_MALPHA = 4'h2;
  localparam logic [3:0] A_UALPHA = 4'h3;
  localparam logic [3:0] A_HI0    = 4'h4;
  localparam logic [3:0] A_LO0    = 4'h7;
  localparam logic [3:0] A_REP0   = 4'hA;
  localparam logic [3:0] A_CMASK  = 4'hD;
  localparam logic [3:0] A_RMASK  = 4'hE;
  localparam logic [3:0] A_HEIGHT = 4'hF;
endpackage

// File: rtl/ck_regs.sv
module ck_regs
  import ck_pkg::*;
#(
  parameter int PW     = 16,
  parameter int AW     = 16,
  parameter int LW     = 16,
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              apply,
  input  logic              busy,
  output logic              pending,
  output logic              commit_req,
  output logic [LW-1:0]     height,
  output logic [PW-1:0]     eff_hi  [NPL],
  output logic [PW-1:0]     eff_lo  [NPL],
  output logic [PW-1:0]     eff_rep [NPL],
  output logic [NPL-1:0]    eff_cmask,
  output logic [NPL-1:0]    eff_rmask,
  output logic [AW-1:0]     eff_ma,
  output logic [AW-1:0]     eff_ua
);
  logic [PW-1:0]  sh_hi [NPL], sh_lo [NPL], sh_rep [NPL];
  logic [PW-1:0]  ac_hi [NPL], ac_lo [NPL], ac_rep [NPL];
  logic [NPL-1:0] sh_cmask, sh_rmask, ac_cmask, ac_rmask;
  logic [AW-1:0]  sh_ma, sh_ua, ac_ma, ac_ua;

  logic [3:0] wa;
  logic       we_ma, we_ua, we_cm, we_rm, we_ht, we_commit, we_set;
  logic [NPL-1:0] we_hi, we_lo, we_rep;
  logic       pending_n, commit_n;
  logic       unused_wr;

  assign wa        = wr_addr[3:0];
  assign unused_wr = ^{wr_data, wr_addr, rd_addr};

  always_comb begin
    we_ma     = wr_en && (wa == A_MALPHA);
    we_ua     = wr_en && (wa == A_UALPHA);
    we_cm     = wr_en && (wa == A_CMASK);
    we_rm     = wr_en && (wa == A_RMASK);
    we_ht     = wr_en && (wa == A_HEIGHT);
    we_commit = wr_en && (wa == A_COMMIT);
    for (int i = 0; i < NPL; i++) begin
      we_hi[i]  = wr_en && (wa == 4'(A_HI0 + i));
      we_lo[i]  = wr_en && (wa == 4'(A_LO0 + i));
      we_rep[i] = wr_en && (wa == 4'(A_REP0 + i));
    end
    we_set = we_ma | we_ua | we_cm | we_rm | (|we_hi) | (|we_lo) | (|we_rep);
  end

  always_comb begin
    pending_n = pending;
    if (apply)  pending_n = 1'b0;
    if (we_set) pending_n = 1'b1;
    commit_n = commit_req;
    if (apply)     commit_n = 1'b0;
    if (we_commit) commit_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      commit_req <= 1'b0;
      height     <= '0;
    end else begin
      pending    <= pending_n;
      commit_req <= commit_n;
      if (we_ht) height <= wr_data[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ma <= '0; sh_ua <= '0; sh_cmask <= '0; sh_rmask <= '0;
      for (int i = 0; i < NPL; i++) begin
        sh_hi[i] <= '0; sh_lo[i] <= '0; sh_rep[i] <= '0;
      end
    end else begin
      if (we_ma) sh_ma    <= wr_data[AW-1:0];
      if (we_ua) sh_ua    <= wr_data[AW-1:0];
      if (we_cm) sh_cmask <= wr_data[NPL-1:0];
      if (we_rm) sh_rmask <= wr_data[NPL-1:0];
      for (int i = 0; i < NPL; i++) begin
        if (we_hi[i])  sh_hi[i]  <= wr_data[PW-1:0];
        if (we_lo[i])  sh_lo[i]  <= wr_data[PW-1:0];
        if (we_rep[i]) sh_rep[i] <= wr_data[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_ma <= '0; ac_ua <= '0; ac_cmask <= '0; ac_rmask <= '0;
      for (int i = 0; i < NPL; i++) begin
        ac_hi[i] <= '0; ac_lo[i] <= '0; ac_rep[i] <= '0;
      end
    end else if (apply) begin
      ac_ma <= sh_ma; ac_ua <= sh_ua; ac_cmask <= sh_cmask; ac_rmask <= sh_rmask;
      for (int i = 0; i < NPL; i++) begin
        ac_hi[i] <= sh_hi[i]; ac_lo[i] <= sh_lo[i]; ac_rep[i] <= sh_rep[i];
      end
    end
  end

  // Settings seen by the datapath: the beat that triggers a transfer already uses the new copy.
  always_comb begin
    eff_ma    = apply ? sh_ma    : ac_ma;
    eff_ua    = apply ? sh_ua    : ac_ua;
    eff_cmask = apply ? sh_cmask : ac_cmask;
    eff_rmask = apply ? sh_rmask : ac_rmask;
    for (int i = 0; i < NPL; i++) begin
      eff_hi[i]  = apply ? sh_hi[i]  : ac_hi[i];
      eff_lo[i]  = apply ? sh_lo[i]  : ac_lo[i];
      eff_rep[i] = apply ? sh_rep[i] : ac_rep[i];
    end
  end

  logic       rd_act;
  logic [3:0] ra;
  assign rd_act = rd_addr[4];
  assign ra     = rd_addr[3:0];

  always_comb begin
    rd_data = '0;
    case (ra)
      A_STATUS: rd_data = DW'({pending, busy});
      A_MALPHA: rd_data = DW'(rd_act ? ac_ma : sh_ma);
      A_UALPHA: rd_data = DW'(rd_act ? ac_ua : sh_ua);
      A_CMASK:  rd_data = DW'(rd_act ? ac_cmask : sh_cmask);
      A_RMASK:  rd_data = DW'(rd_act ? ac_rmask : sh_rmask);
      A_HEIGHT: rd_data = DW'(height);
      default:  rd_data = '0;
    endcase
    for (int i = 0; i < NPL; i++) begin
      if (ra == 4'(A_HI0 + i))  rd_data = DW'(rd_act ? ac_hi[i]  : sh_hi[i]);
      if (ra == 4'(A_LO0 + i))  rd_data = DW'(rd_act ? ac_lo[i]  : sh_lo[i]);
      if (ra == 4'(A_REP0 + i)) rd_data = DW'(rd_act ? ac_rep[i] : sh_rep[i]);
    end
  end
endmodule

// File: rtl/ck_field.sv
module ck_field #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          sof,
  input  logic          eol,
  input  logic [LW-1:0] height,
  output logic          busy
);
  logic [LW-1:0] line_cnt, line_n, base;
  logic          busy_n, live;
  logic [LW:0]   done_lines;

  always_comb begin
    base       = (accept && sof) ? '0 : line_cnt;
    live       = busy || (accept && sof);
    done_lines = {1'b0, base} + 1'b1;
    busy_n     = busy;
    line_n     = line_cnt;
    if (accept && eol && live) begin
      if (done_lines >= {1'b0, height}) begin
        busy_n = 1'b0;
        line_n = '0;
      end else begin
        busy_n = 1'b1;
        line_n = done_lines[LW-1:0];
      end
    end else if (accept && sof) begin
      busy_n = 1'b1;
      line_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      line_cnt <= '0;
    end else begin
      busy     <= busy_n;
      line_cnt <= line_n;
    end
  end
endmodule

// File: rtl/ck_key.sv
module ck_key
  import ck_pkg::*;
#(
  parameter int            PW          = 16,
  parameter int            AW          = 16,
  parameter bit            CONST_ALPHA = 1'b0,
  parameter logic [AW-1:0] CONST_TAG   = '0
) (
  input  logic [NPL*PW-1:0]    pix,
  input  logic [PW-1:0]        hi  [NPL],
  input  logic [PW-1:0]        lo  [NPL],
  input  logic [PW-1:0]        rep [NPL],
  input  logic [NPL-1:0]       cmask,
  input  logic [NPL-1:0]       rmask,
  input  logic [AW-1:0]        ma,
  input  logic [AW-1:0]        ua,
  output logic [NPL*PW+AW-1:0] res
);
  generate
    if (CONST_ALPHA) begin : g_const
      logic [NPL:0] unused_cfg;
      for (genvar i = 0; i < NPL; i++) begin : g_drop
        assign unused_cfg[i] = ^{hi[i], lo[i], rep[i]};
      end
      assign unused_cfg[NPL] = ^{cmask, rmask, ma, ua};
      assign res = {pix, CONST_TAG};
    end else begin : g_key
      logic [NPL-1:0]    in_rng;
      logic [NPL*PW-1:0] outp;
      logic              hit;
      for (genvar i = 0; i < NPL; i++) begin : g_pl
        localparam int MSB = NPL*PW - 1 - i*PW;
        logic [PW-1:0] v;
        assign v = pix[MSB -: PW];
        assign in_rng[i] = (v >= lo[i]) && (v <= hi[i]);
        assign outp[MSB -: PW] = (hit && rmask[i]) ? rep[i] : v;
      end
      assign hit = &(in_rng | ~cmask);
      assign res = {outp, hit ? ma : ua};
    end
  endgenerate
endmodule

// File: rtl/chroma_key_tagger.sv
module chroma_key_tagger
  import ck_pkg::*;
#(
  parameter int            PW          = 16,
  parameter int            ALPHA_W     = 16,
  parameter int            LW          = 16,
  parameter int            ADDR_W      = 5,
  parameter int            DW          = 32,
  parameter bit            CONST_ALPHA = 1'b0,
  parameter logic [ALPHA_W-1:0] CONST_TAG = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NPL*PW-1:0]         in_data,
  input  logic                      in_sof,
  input  logic                      in_eol,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NPL*PW+ALPHA_W-1:0] out_data,
  output logic                      out_sof,
  output logic                      out_eol,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DW-1:0]             rd_data
);
  localparam int OUT_W = NPL*PW + ALPHA_W;

  logic accept, busy, pending, commit_req, apply;
  logic [LW-1:0]      height;
  logic [PW-1:0]      e_hi [NPL], e_lo [NPL], e_rep [NPL];
  logic [NPL-1:0]     e_cm, e_rm;
  logic [ALPHA_W-1:0] e_ma, e_ua;
  logic [OUT_W-1:0]   keyed;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign apply    = commit_req && (!busy || (accept && in_sof));

  ck_regs #(.PW(PW), .AW(ALPHA_W), .LW(LW), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .apply(apply), .busy(busy),
    .pending(pending), .commit_req(commit_req), .height(height),
    .eff_hi(e_hi), .eff_lo(e_lo), .eff_rep(e_rep), .eff_cmask(e_cm),
    .eff_rmask(e_rm), .eff_ma(e_ma), .eff_ua(e_ua)
  );

  ck_field #(.LW(LW)) u_field (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof), .eol(in_eol),
    .height(height), .busy(busy)
  );

  ck_key #(.PW(PW), .AW(ALPHA_W), .CONST_ALPHA(CONST_ALPHA), .CONST_TAG(CONST_TAG)) u_key (
    .pix(in_data), .hi(e_hi), .lo(e_lo), .rep(e_rep), .cmask(e_cm), .rmask(e_rm),
    .ma(e_ma), .ua(e_ua), .res(keyed)
  );

  logic             ov_n, sof_n, eol_n;
  logic [OUT_W-1:0] od_n;

  always_comb begin
    ov_n  = out_valid;
    od_n  = out_data;
    sof_n = out_sof;
    eol_n = out_eol;
    if (in_ready) begin
      ov_n  = in_valid;
      od_n  = keyed;
      sof_n = in_sof;
      eol_n = in_eol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= ov_n;
      out_data  <= od_n;
      out_sof   <= sof_n;
      out_eol   <= eol_n;
    end
  end
endmodule

// File: rtl/ck_tagger_chk.sv
module ck_tagger_chk #(
  parameter int            OUT_W       = 64,
  parameter int            AW          = 16,
  parameter int            ADDR_W      = 5,
  parameter bit            CONST_ALPHA = 1'b0,
  parameter logic [AW-1:0] CONST_TAG   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pending,
  input logic              commit_req,
  input logic              apply,
  input logic              busy
);
  logic set_wr;
  assign set_wr = wr_en && (wr_addr[3:0] >= 4'h2) && (wr_addr[3:0] <= 4'hE);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> pending);

  p_pend_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(apply));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready && in_sof));

  p_idle_apply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req && !busy && !wr_en |=> !commit_req);

  generate
    if (CONST_ALPHA) begin : g_const_chk
      p_const_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[AW-1:0] == CONST_TAG);
    end
  endgenerate
endmodule

bind chroma_key_tagger ck_tagger_chk #(
  .OUT_W(OUT_W), .AW(ALPHA_W), .ADDR_W(ADDR_W),
  .CONST_ALPHA(CONST_ALPHA), .CONST_TAG(CONST_TAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .pending(pending), .commit_req(commit_req),
  .apply(apply), .busy(busy)
);

// File: tb/tb_chroma_key_tagger.sv
`timescale 1ns/1ps
module tb_chroma_key_tagger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 0, in_sof = 0, in_eol = 0, out_ready = 1;
  logic [47:0] in_data = '0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        in_ready, out_valid, out_sof, out_eol;
  logic [63:0] out_data;
  logic [31:0] rd_data;
  logic        in_ready_c, out_valid_c, out_sof_c, out_eol_c;
  logic [63:0] out_data_c;
  logic [31:0] rd_data_c;

  int checks = 0, errs = 0;
  bit done = 0;

  chroma_key_tagger dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  chroma_key_tagger #(.CONST_ALPHA(1'b1), .CONST_TAG(16'h0F0F)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid_c), .out_ready(out_ready),
    .out_data(out_data_c), .out_sof(out_sof_c), .out_eol(out_eol_c), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_c));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] px(input logic [15:0] a, b, c, al);
    return {a, b, c, al};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr = a; #1;
    chk(req, {32'h0, rd_data}, {32'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one beat, then look at the registered result in the following low phase.
  task automatic send(input logic [15:0] a, b, c, input logic s, e);
    @(negedge clk);
    in_valid = 1; in_data = {a, b, c}; in_sof = s; in_eol = e;
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eol = 0;
  endtask

  task automatic cfg_base();
    wr(5'h04, 20);  wr(5'h07, 10);
    wr(5'h05, 200); wr(5'h08, 100);
    wr(5'h06, 5);   wr(5'h09, 0);
    wr(5'h0A, 16'h1111); wr(5'h0B, 16'h2222); wr(5'h0C, 16'h3333);
    wr(5'h0D, 3'b111); wr(5'h0E, 3'b101);
    wr(5'h02, 16'hAAAA); wr(5'h03, 16'h5555);
    wr(5'h0F, 2);
    wr(5'h01, 0);
    idle(2);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 out_valid", {63'h0, out_valid}, 64'h0);
    chk("R11 in_ready", {63'h0, in_ready}, 64'h1);
    rd_chk("R11 status", 5'h00, 0);
    rd_chk("R11 active alpha", 5'h12, 0);
  endtask

  task automatic t_match();
    cfg_base();
    rd_chk("R10 idle apply pending clear", 5'h00, 0);
    rd_chk("R9 active lower C1", 5'h17, 10);
    send(10, 200, 5, 0, 0);
    chk("R1 R2 R3 hit at limits", out_data, px(16'h1111, 200, 16'h3333, 16'hAAAA));
    chk("R8 valid after one edge", {63'h0, out_valid}, 64'h1);
    send(9, 150, 3, 0, 0);
    chk("R1 R2 below lower", out_data, px(9, 150, 3, 16'h5555));
    send(20, 201, 0, 0, 1);
    chk("R1 above upper", out_data, px(20, 201, 0, 16'h5555));
    chk("R8 eol passes", {63'h0, out_eol}, 64'h1);
    wr(5'h0D, 0); wr(5'h01, 0); idle(2);
    send(999, 999, 999, 0, 0);
    chk("R1 zero mask hits", out_data, px(16'h1111, 999, 16'h3333, 16'hAAAA));
    wr(5'h0D, 3'b010); wr(5'h0E, 3'b010); wr(5'h01, 0); idle(2);
    send(999, 150, 999, 0, 0);
    chk("R1 R3 only C2 compared and replaced", out_data, px(999, 16'h2222, 999, 16'hAAAA));
    send(999, 99, 999, 0, 0);
    chk("R3 miss not replaced", out_data, px(999, 99, 999, 16'h5555));
  endtask

  task automatic t_readback();
    wr(5'h0E, 32'hFFFF_FFFF);
    rd_chk("R9 shadow mask upper bits zero", 5'h0E, 7);
    rd_chk("R9 active still old", 5'h1E, 2);
    rd_chk("R6 pending after write", 5'h00, 2);
    wr(5'h01, 0); idle(2);
    rd_chk("R9 active after commit", 5'h1E, 7);
    wr(5'h03, 32'hDEAD_5555);
    rd_chk("R9 alpha upper bits zero", 5'h03, 16'h5555);
    wr(5'h01, 0); idle(2);
  endtask

  task automatic t_shadow();
    cfg_base();
    send(10, 200, 5, 1, 0);
    chk("R2 first beat of field", out_data, px(16'h1111, 200, 16'h3333, 16'hAAAA));
    chk("R8 sof passes", {63'h0, out_sof}, 64'h1);
    rd_chk("R7 busy in field", 5'h00, 1);
    wr(5'h02, 16'h1234);
    rd_chk("R6 pending set", 5'h00, 3);
    send(10, 200, 5, 0, 0);
    chk("R5 no effect before commit", out_data, px(16'h1111, 200, 16'h3333, 16'hAAAA));
    wr(5'h01, 0); idle(2);
    rd_chk("R6 pending held in field", 5'h00, 3);
    rd_chk("R9 shadow new", 5'h02, 16'h1234);
    rd_chk("R9 active old", 5'h12, 16'hAAAA);
    send(10, 200, 5, 0, 1);
    chk("R5 old settings mid field", out_data, px(16'h1111, 200, 16'h3333, 16'hAAAA));
    rd_chk("R7 busy after first line", 5'h00, 3);
    send(10, 200, 5, 0, 1);
    chk("R5 old settings on last beat", out_data, px(16'h1111, 200, 16'h3333, 16'hAAAA));
    idle(2);
    rd_chk("R6 R7 field ended, applied", 5'h00, 0);
    send(10, 200, 5, 0, 0);
    chk("R5 new alpha after boundary", out_data, px(16'h1111, 200, 16'h3333, 16'h1234));
  endtask

  task automatic t_backpressure();
    cfg_base();
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_data = {16'd9, 16'd150, 16'd3};
    @(negedge clk);
    in_data = {16'd10, 16'd200, 16'd5};
    chk("R8 stall in_ready low", {63'h0, in_ready}, 64'h0);
    chk("R8 first held", out_data, px(9, 150, 3, 16'h5555));
    @(negedge clk);
    chk("R8 still held", out_data, px(9, 150, 3, 16'h5555));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 second after release", out_data, px(16'h1111, 200, 16'h3333, 16'hAAAA));
    @(negedge clk);
    chk("R8 drains", {63'h0, out_valid}, 64'h0);
  endtask

  task automatic t_const();
    cfg_base();
    send(10, 200, 5, 0, 0);
    chk("R4 fixed tag on hit", out_data_c, px(10, 200, 5, 16'h0F0F));
    send(9, 150, 3, 0, 0);
    chk("R4 fixed tag on miss", out_data_c, px(9, 150, 3, 16'h0F0F));
  endtask

  task automatic t_restart();
    cfg_base();
    wr(5'h0F, 100);
    send(9, 150, 3, 1, 0);
    chk("R2 miss in long field", out_data, px(9, 150, 3, 16'h5555));
    wr(5'h03, 16'h7777); wr(5'h01, 0); idle(3);
    rd_chk("R10 waits for field start", 5'h00, 3);
    send(9, 150, 3, 1, 0);
    chk("R10 restart beat uses new", out_data, px(9, 150, 3, 16'h7777));
    rd_chk("R10 pending cleared, busy", 5'h00, 1);
    wr(5'h0F, 1);
    send(9, 150, 3, 0, 1);
    idle(1);
    rd_chk("R7 height write immediate", 5'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_match();
    t_readback();
    t_shadow();
    t_backpressure();
    t_const();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule